// File: doc/BRIEF.md
# Reaction cycle sequencer

This block is the per-thread control engine of a hardware stochastic biochemical simulator built on the next-reaction method. One sequencer belongs to each simulation thread. It owns no arithmetic. It steps one reaction cycle by sending commands, one at a time, to calculation units that other threads also use. A command is a one-cycle pulse on the unit's request line, carrying a reaction id and an operand on a shared command bus. The unit later returns a one-cycle done pulse, with its result on its own result slice.

A cycle starts from the reaction and time at the root of the thread's priority heap. The sequencer applies the fired reaction's state change. It fetches the reaction's propensity and draws a fresh firing time, then writes that time into the heap. It then reads the reaction's dependency list. For every other reaction on that list, it asks for a rescaled time and writes each rescaled time back to the heap. An initialization pass computes a time for every reaction and inserts each one into the heap before the first cycle runs.

Top module: `rxn_cycle_seq`

## Requirements
- R1: While rst_n is low at a clock edge, and after that edge, busy, cycle_done, init_done and every unit_req bit are 0 and sim_time is 0.
- R2: A start_cycle pulse while idle captures root_rxn as the fired reaction m and root_time as its time t. The sequencer then issues, in this order: state update (unit_req bit 0), propensity (bit 1), new time (bit 2), heap update (bit 4) and dependency header (bit 5), each with cmd_rxn = m. The operand is 0 for the state update, propensity and header commands.
- R3: The new-time command carries the propensity result as its operand. The heap update that follows carries the new-time result and reaction m.
- R4: The header result holds the list base address in its low DG_ADDR_W bits and the entry count in the next LEN_W bits. The entries are read with dependency-entry commands (bit 6, cmd_rxn = m, operand = address) at base, base+1, and so on, in ascending order. Addresses wrap modulo 2^DG_ADDR_W. Each entry result carries a reaction id in its low RID_W bits.
- R5: For each entry j not equal to m, a modify command (bit 3, cmd_rxn = j, operand = t) is issued. It is followed by a heap update with reaction j and the modify result, before the next entry is read. A list of d entries that contains m yields d-1 modifications.
- R6: An entry equal to m issues neither a modify nor a heap update. The sequencer goes straight on to the next entry.
- R7: A header with a zero count ends the cycle right after the header result arrives.
- R8: After the last result of a cycle, cycle_done pulses for exactly one clock. When busy falls, sim_time equals t.
- R9: A start_init pulse while idle runs, for each reaction r = 0 to NUM_RXN-1 in ascending order, three commands: propensity (r), new time (r, operand = propensity result), and heap update (r, operand = new-time result). It then pulses init_done for one clock and sets sim_time to 0.
- R10: At most one unit_req bit is high in any cycle. No request is issued between a request and the done pulse of the unit that received it.
- R11: start_init and start_cycle have no effect while busy. If both arrive while idle, initialization wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_init | input | 1 | Pulse: run the initialization pass |
| start_cycle | input | 1 | Pulse: run one reaction cycle |
| root_rxn | input | RID_W | Reaction id at the heap root |
| root_time | input | DATA_W | Firing time at the heap root |
| busy | output | 1 | A pass is in progress |
| cycle_done | output | 1 | One-clock pulse at the end of a reaction cycle |
| init_done | output | 1 | One-clock pulse at the end of initialization |
| sim_time | output | DATA_W | Current simulation time |
| unit_req | output | NUM_UNIT | One-cycle request pulse, one bit per unit |
| cmd_rxn | output | RID_W | Reaction id of the current command |
| cmd_arg | output | DATA_W | Operand of the current command |
| unit_done | input | NUM_UNIT | One-cycle result pulse, one bit per unit |
| unit_res | input | NUM_UNIT*DATA_W | Result slices, DATA_W bits per unit |

## Verification
The bench builds the sequencer with four reactions, a 16-entry dependency store (4 address bits) and 3-bit list counts. At that size, every reaction can be fired under each of four dependency layouts. The layouts cover the fired reaction first, last, or absent from its list, lists made only of self-entries, an empty list, and a list whose base wraps past the end of the store. The initialization pass visits every reaction. The stub units answer after a latency that differs per unit. The bench then compares the full command log against a sequence it derives from the tables.

// File: rtl/rxn_seq_pkg.sv
// Shared unit indices and sequencer states for the reaction cycle sequencer.
package rxn_seq_pkg;
    localparam int NUM_UNIT = 7;
    localparam int U_UPD    = 0;   // state update
    localparam int U_PRP    = 1;   // reactant fetch and propensity
    localparam int U_TCAL   = 2;   // fresh firing time
    localparam int U_TMOD   = 3;   // rescaled firing time
    localparam int U_HEAP   = 4;   // heap update
    localparam int U_DGH    = 5;   // dependency header
    localparam int U_DGE    = 6;   // dependency entry

    typedef enum logic [3:0] {
        S_IDLE, S_UPD, S_PRP, S_TCAL, S_HPF,
        S_DGH, S_DGE, S_TMOD, S_HPD, S_DONE
    } seq_state_t;
endpackage

// File: rtl/rxn_unit_link.sv
// One request/result link to a shared unit.
// Tracks whether a command is outstanding and qualifies the unit's done
// pulse with it. Assumes the unit answers each request with one done pulse.
module rxn_unit_link (
    input  logic clk,
    input  logic rst_n,
    input  logic issue,
    input  logic done,
    output logic req,
    output logic got,
    output logic pend
);
    assign req = issue;
    assign got = done & pend;

    // Outstanding flag: set by a request, cleared by its result.
    always_ff @(posedge clk) begin
        if (!rst_n)      pend <= 1'b0;
        else if (issue)  pend <= 1'b1;
        else if (done)   pend <= 1'b0;
    end

    // R10: never reissue on a link that still waits for its result
    a_r10_no_reissue: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> !pend);
endmodule

// File: rtl/rxn_dep_walker.sv
// Dependency-list walker.
// Holds the base and count of the list just read and steps an index through it.
// Assumes load happens only with a nonzero count, and step only while entries remain.
module rxn_dep_walker #(
    parameter int DG_ADDR_W = 12,
    parameter int LEN_W     = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [DG_ADDR_W-1:0] base_in,
    input  logic [LEN_W-1:0]     len_in,
    input  logic                 step,
    output logic [DG_ADDR_W-1:0] addr,
    output logic                 last
);
    logic [DG_ADDR_W-1:0] base_q;
    logic [LEN_W-1:0]     len_q;
    logic [LEN_W-1:0]     idx_q;

    // List window registers: load a new list or advance the index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            len_q  <= '0;
            idx_q  <= '0;
        end else if (load) begin
            base_q <= base_in;
            len_q  <= len_in;
            idx_q  <= '0;
        end else if (step) begin
            idx_q  <= idx_q + LEN_W'(1);
        end
    end

    assign addr = base_q + DG_ADDR_W'(idx_q);
    assign last = (idx_q == len_q - LEN_W'(1));

    // R4: the index never steps past the end of the list
    a_r4_step_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (idx_q < len_q));
endmodule

// File: rtl/rxn_seq_fsm.sv
// Reaction cycle state machine.
// Sequences the cycle and initialization passes, one command at a time,
// and captures each unit's result. Assumes results arrive only on the unit
// addressed by the current state (guaranteed by the links).
module rxn_seq_fsm
    import rxn_seq_pkg::*;
#(
    parameter int NUM_RXN   = 1024,
    parameter int DATA_W    = 32,
    parameter int DG_ADDR_W = 12,
    parameter int LEN_W     = 6,
    localparam int RID_W    = $clog2(NUM_RXN)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_init,
    input  logic                       start_cycle,
    input  logic [RID_W-1:0]           root_rxn,
    input  logic [DATA_W-1:0]          root_time,
    input  logic [NUM_UNIT-1:0]        got,
    input  logic [NUM_UNIT*DATA_W-1:0] unit_res,
    input  logic [DG_ADDR_W-1:0]       walk_addr,
    input  logic                       walk_last,
    output logic [NUM_UNIT-1:0]        issue,
    output logic [RID_W-1:0]           cmd_rxn,
    output logic [DATA_W-1:0]          cmd_arg,
    output logic                       walk_load,
    output logic [DG_ADDR_W-1:0]       walk_base,
    output logic [LEN_W-1:0]           walk_len,
    output logic                       walk_step,
    output logic                       busy,
    output logic                       cycle_done,
    output logic                       init_done,
    output logic [DATA_W-1:0]          sim_time
);
    seq_state_t          state;
    logic                issued;
    logic                init_mode;
    logic [RID_W-1:0]    rxn_q;
    logic [RID_W-1:0]    dep_q;
    logic [DATA_W-1:0]   tfire_q;
    logic [DATA_W-1:0]   prop_q;
    logic [DATA_W-1:0]   tval_q;
    logic [DATA_W-1:0]   sim_q;
    logic [NUM_UNIT-1:0] sel;
    logic [DATA_W-1:0]   res_cur;
    logic                done_cur;
    logic [RID_W-1:0]    dep_id;
    logic                is_self;
    logic                last_rxn;

    // Unit addressed by each state.
    always_comb begin
        sel = '0;
        case (state)
            S_UPD:         sel[U_UPD]  = 1'b1;
            S_PRP:         sel[U_PRP]  = 1'b1;
            S_TCAL:        sel[U_TCAL] = 1'b1;
            S_HPF, S_HPD:  sel[U_HEAP] = 1'b1;
            S_DGH:         sel[U_DGH]  = 1'b1;
            S_DGE:         sel[U_DGE]  = 1'b1;
            S_TMOD:        sel[U_TMOD] = 1'b1;
            default:       ;
        endcase
    end

    // Result of the addressed unit.
    always_comb begin
        res_cur = '0;
        for (int k = 0; k < NUM_UNIT; k++) begin
            if (sel[k]) res_cur = unit_res[k*DATA_W +: DATA_W];
        end
    end

    assign done_cur = |(got & sel);
    assign issue    = issued ? '0 : sel;
    assign dep_id   = res_cur[RID_W-1:0];
    assign is_self  = (dep_id == rxn_q);
    assign last_rxn = (rxn_q == RID_W'(NUM_RXN - 1));

    // Command bus contents for the current state.
    always_comb begin
        cmd_rxn = rxn_q;
        cmd_arg = '0;
        case (state)
            S_TCAL: cmd_arg = prop_q;
            S_HPF:  cmd_arg = tval_q;
            S_DGE:  cmd_arg = DATA_W'(walk_addr);
            S_TMOD: begin cmd_rxn = dep_q; cmd_arg = tfire_q; end
            S_HPD:  begin cmd_rxn = dep_q; cmd_arg = tval_q;  end
            default: ;
        endcase
    end

    // Walker control: load on header, step past a skipped or finished entry.
    assign walk_load = done_cur && (state == S_DGH);
    assign walk_base = res_cur[DG_ADDR_W-1:0];
    assign walk_len  = res_cur[DG_ADDR_W +: LEN_W];
    assign walk_step = done_cur && !walk_last &&
                       ((state == S_DGE && is_self) || state == S_HPD);

    // Sequencing: issue once per state, advance on the matching result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            issued    <= 1'b0;
            init_mode <= 1'b0;
            rxn_q     <= '0;
            dep_q     <= '0;
            tfire_q   <= '0;
            prop_q    <= '0;
            tval_q    <= '0;
            sim_q     <= '0;
        end else begin
            if ((|sel) && !issued) issued <= 1'b1;
            if (done_cur) issued <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (start_init) begin
                        init_mode <= 1'b1;
                        rxn_q     <= '0;
                        state     <= S_PRP;
                    end else if (start_cycle) begin
                        init_mode <= 1'b0;
                        rxn_q     <= root_rxn;
                        tfire_q   <= root_time;
                        state     <= S_UPD;
                    end
                end
                S_UPD:  if (done_cur) state <= S_PRP;
                S_PRP:  if (done_cur) begin prop_q <= res_cur; state <= S_TCAL; end
                S_TCAL: if (done_cur) begin tval_q <= res_cur; state <= S_HPF;  end
                S_HPF: if (done_cur) begin
                    if (!init_mode)    state <= S_DGH;
                    else if (last_rxn) state <= S_DONE;
                    else begin
                        rxn_q <= rxn_q + RID_W'(1);
                        state <= S_PRP;
                    end
                end
                S_DGH: if (done_cur) begin
                    state <= (walk_len == '0) ? S_DONE : S_DGE;
                end
                S_DGE: if (done_cur) begin
                    dep_q <= dep_id;
                    if (!is_self)       state <= S_TMOD;
                    else if (walk_last) state <= S_DONE;
                end
                S_TMOD: if (done_cur) begin tval_q <= res_cur; state <= S_HPD; end
                S_HPD:  if (done_cur) state <= walk_last ? S_DONE : S_DGE;
                S_DONE: begin
                    sim_q <= init_mode ? '0 : tfire_q;
                    state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign busy       = (state != S_IDLE);
    assign cycle_done = (state == S_DONE) && !init_mode;
    assign init_done  = (state == S_DONE) && init_mode;
    assign sim_time   = sim_q;

    // R2: an accepted cycle start issues the state update for the root reaction
    a_r2_update_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && start_cycle && !start_init)
        |=> (issue[U_UPD] && cmd_rxn == $past(root_rxn)));
    // R9: initialization starts with the propensity of reaction zero
    a_r9_init_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && start_init) |=> (issue[U_PRP] && cmd_rxn == '0));
    // R5: a modify result goes straight into a heap update
    a_r5_heap_after_mod: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_TMOD && done_cur)
        |=> (issue[U_HEAP] && cmd_arg == $past(res_cur)));
    // R6: the fired reaction is never rescaled
    a_r6_no_self_mod: assert property (@(posedge clk) disable iff (!rst_n)
        issue[U_TMOD] |-> (cmd_rxn != rxn_q));
    // R8: completion pulse lasts one clock and leaves the block idle
    a_r8_single_done: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |=> (!cycle_done && !busy));
endmodule

// File: rtl/rxn_cycle_seq.sv
// Reaction cycle sequencer top.
// Joins the state machine, the dependency walker and one link per shared
// unit. Assumes each unit answers every request with exactly one done pulse.
module rxn_cycle_seq
    import rxn_seq_pkg::*;
#(
    parameter int NUM_RXN   = 1024,
    parameter int DATA_W    = 32,
    parameter int DG_ADDR_W = 12,
    parameter int LEN_W     = 6,
    localparam int RID_W    = $clog2(NUM_RXN)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_init,
    input  logic                       start_cycle,
    input  logic [RID_W-1:0]           root_rxn,
    input  logic [DATA_W-1:0]          root_time,
    output logic                       busy,
    output logic                       cycle_done,
    output logic                       init_done,
    output logic [DATA_W-1:0]          sim_time,
    output logic [NUM_UNIT-1:0]        unit_req,
    output logic [RID_W-1:0]           cmd_rxn,
    output logic [DATA_W-1:0]          cmd_arg,
    input  logic [NUM_UNIT-1:0]        unit_done,
    input  logic [NUM_UNIT*DATA_W-1:0] unit_res
);
    logic [NUM_UNIT-1:0]  issue;
    logic [NUM_UNIT-1:0]  got;
    logic [NUM_UNIT-1:0]  pend;
    logic                 walk_load;
    logic                 walk_step;
    logic                 walk_last;
    logic [DG_ADDR_W-1:0] walk_base;
    logic [DG_ADDR_W-1:0] walk_addr;
    logic [LEN_W-1:0]     walk_len;

    // One link per shared unit.
    for (genvar g = 0; g < NUM_UNIT; g++) begin : g_link
        rxn_unit_link link_i (
            .clk   (clk),
            .rst_n (rst_n),
            .issue (issue[g]),
            .done  (unit_done[g]),
            .req   (unit_req[g]),
            .got   (got[g]),
            .pend  (pend[g])
        );
    end

    rxn_dep_walker #(
        .DG_ADDR_W (DG_ADDR_W),
        .LEN_W     (LEN_W)
    ) walk_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (walk_load),
        .base_in (walk_base),
        .len_in  (walk_len),
        .step    (walk_step),
        .addr    (walk_addr),
        .last    (walk_last)
    );

    rxn_seq_fsm #(
        .NUM_RXN   (NUM_RXN),
        .DATA_W    (DATA_W),
        .DG_ADDR_W (DG_ADDR_W),
        .LEN_W     (LEN_W)
    ) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_init  (start_init),
        .start_cycle (start_cycle),
        .root_rxn    (root_rxn),
        .root_time   (root_time),
        .got         (got),
        .unit_res    (unit_res),
        .walk_addr   (walk_addr),
        .walk_last   (walk_last),
        .issue       (issue),
        .cmd_rxn     (cmd_rxn),
        .cmd_arg     (cmd_arg),
        .walk_load   (walk_load),
        .walk_base   (walk_base),
        .walk_len    (walk_len),
        .walk_step   (walk_step),
        .busy        (busy),
        .cycle_done  (cycle_done),
        .init_done   (init_done),
        .sim_time    (sim_time)
    );

    // R10: one request at a time, never while another command is outstanding
    a_r10_single_request: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(unit_req) && (!(|unit_req) || !(|pend)));
endmodule

// File: tb/rxn_cycle_seq_tb.sv
// Bench: stub units with per-unit latency, full command-log comparison.
module rxn_cycle_seq_tb_top;
    import rxn_seq_pkg::*;
    localparam int NR = 4;
    localparam int DW = 32;
    localparam int AW = 4;
    localparam int LW = 3;
    localparam int RW = $clog2(NR);
    localparam int NU = NUM_UNIT;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_init = 1'b0;
    logic start_cycle = 1'b0;
    logic [RW-1:0] root_rxn = '0;
    logic [DW-1:0] root_time = '0;
    logic busy, cycle_done, init_done;
    logic [DW-1:0] sim_time;
    logic [NU-1:0] unit_req;
    logic [RW-1:0] cmd_rxn;
    logic [DW-1:0] cmd_arg;
    logic [NU-1:0] unit_done;
    logic [NU*DW-1:0] unit_res;

    always #2 clk = ~clk;

    rxn_cycle_seq #(.NUM_RXN(NR), .DATA_W(DW), .DG_ADDR_W(AW), .LEN_W(LW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_init(start_init), .start_cycle(start_cycle),
        .root_rxn(root_rxn), .root_time(root_time), .busy(busy),
        .cycle_done(cycle_done), .init_done(init_done), .sim_time(sim_time),
        .unit_req(unit_req), .cmd_rxn(cmd_rxn), .cmd_arg(cmd_arg),
        .unit_done(unit_done), .unit_res(unit_res));

    // Dependency tables the stubs serve.
    int dep_mem [16];
    int hb [NR];
    int hl [NR];

    int log_u [1024];
    int log_r [1024];
    int log_a [1024];
    int log_n;
    int ovl;
    int n_cdone;
    int n_idone;
    int st_cnt [NU];
    int st_res [NU];
    logic [NU-1:0] st_busy;

    int exp_u [256];
    int exp_r [256];
    int exp_a [256];
    int exp_n;
    int n_chk = 0;
    int n_fail = 0;

    function automatic int f_tcal(int r, int a);
        return a * 8 + r + 3;
    endfunction
    function automatic int f_tmod(int r, int t);
        return t + 5 * r + 2;
    endfunction

    function automatic int stub_result(int k, int r, int a);
        case (k)
            U_PRP:  return r + 1;
            U_TCAL: return f_tcal(r, a);
            U_TMOD: return f_tmod(r, a);
            U_DGH:  return (hl[r] << AW) | hb[r];
            U_DGE:  return dep_mem[a % 16];
            default: return 0;
        endcase
    endfunction

    // Stub units: fixed latency k+1, command log, overlap and pulse counters.
    always @(posedge clk) begin
        if (!rst_n) begin
            st_busy <= '0; unit_done <= '0; unit_res <= '0;
            log_n <= 0; ovl <= 0; n_cdone <= 0; n_idone <= 0;
        end else begin
            unit_done <= '0;
            if (cycle_done) n_cdone <= n_cdone + 1;
            if (init_done)  n_idone <= n_idone + 1;
            if ($countones(unit_req) > 1 || ((|unit_req) && (|st_busy))) ovl <= ovl + 1;
            for (int k = 0; k < NU; k++) begin
                if (unit_req[k]) begin
                    st_busy[k] <= 1'b1;
                    st_cnt[k]  <= k + 1;
                    st_res[k]  <= stub_result(k, int'(cmd_rxn), int'(cmd_arg));
                    log_u[log_n] <= k;
                    log_r[log_n] <= int'(cmd_rxn);
                    log_a[log_n] <= int'(cmd_arg);
                    log_n <= log_n + 1;
                end else if (st_busy[k]) begin
                    if (st_cnt[k] == 1) begin
                        st_busy[k] <= 1'b0;
                        unit_done[k] <= 1'b1;
                        unit_res[k*DW +: DW] <= DW'(st_res[k]);
                    end else begin
                        st_cnt[k] <= st_cnt[k] - 1;
                    end
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic add(input int u, input int r, input int a);
        exp_u[exp_n] = u; exp_r[exp_n] = r; exp_a[exp_n] = a; exp_n++;
    endtask

    task automatic exp_cycle(input int mu, input int tm);
        int t;
        exp_n = 0;
        add(U_UPD, mu, 0);
        add(U_PRP, mu, 0);
        add(U_TCAL, mu, mu + 1);
        t = f_tcal(mu, mu + 1);
        add(U_HEAP, mu, t);
        add(U_DGH, mu, 0);
        for (int i = 0; i < hl[mu]; i++) begin
            int ad = (hb[mu] + i) % 16;
            int j = dep_mem[ad];
            add(U_DGE, mu, ad);
            if (j != mu) begin
                add(U_TMOD, j, tm);
                add(U_HEAP, j, f_tmod(j, tm));
            end
        end
    endtask

    task automatic exp_init();
        exp_n = 0;
        for (int r = 0; r < NR; r++) begin
            add(U_PRP, r, 0);
            add(U_TCAL, r, r + 1);
            add(U_HEAP, r, f_tcal(r, r + 1));
        end
    endtask

    task automatic set_pat(input int p);
        for (int i = 0; i < 16; i++) dep_mem[i] = 0;
        for (int r = 0; r < NR; r++) begin
            case (p)
                0: begin hb[r] = 4 * r; hl[r] = 4;
                         for (int i = 0; i < 4; i++) dep_mem[4*r+i] = (r + i) % 4; end
                1: begin hb[r] = 4 * r; hl[r] = r;
                         for (int i = 0; i < 4; i++) dep_mem[4*r+i] = 3 - i; end
                2: begin hb[r] = 4 * r; hl[r] = 2;
                         for (int i = 0; i < 4; i++) dep_mem[4*r+i] = r; end
                default: begin hb[r] = 14; hl[r] = 4; end
            endcase
        end
        if (p == 3) begin
            dep_mem[14] = 0; dep_mem[15] = 1; dep_mem[0] = 2; dep_mem[1] = 3;
        end
    endtask

    task automatic pulse(input bit ini, input bit cyc, input int mu, input int tm);
        @(negedge clk);
        root_rxn = RW'(mu); root_time = DW'(tm);
        start_init = ini; start_cycle = cyc;
        @(negedge clk);
        start_init = 1'b0; start_cycle = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 3000) begin @(negedge clk); n++; end
        check(!busy, "R8 pass did not finish", int'(busy), 0);
    endtask

    task automatic cmp_log(input int base, input string tag);
        int bad = -1;
        check(log_n - base == exp_n, {tag, " command count"}, log_n - base, exp_n);
        for (int i = 0; i < exp_n; i++) begin
            if (bad < 0 && (log_u[base+i] != exp_u[i] || log_r[base+i] != exp_r[i] ||
                            log_a[base+i] != exp_a[i])) bad = i;
        end
        if (bad >= 0)
            check(0, {tag, " command content (unit*1000+rxn)"},
                  log_u[base+bad]*1000 + log_r[base+bad], exp_u[bad]*1000 + exp_r[bad]);
        else
            check(1, tag, 0, 0);
    endtask

    function automatic int count_unit(input int base, input int u);
        int c = 0;
        for (int i = base; i < log_n; i++) if (log_u[i] == u) c++;
        return c;
    endfunction

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog actual=expired expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        int b, cd, idn;
        repeat (5) @(negedge clk);
        // R1: reset state
        check(!busy && !cycle_done && !init_done && unit_req == '0 && sim_time == '0,
              "R1 reset state", int'(busy), 0);
        rst_n = 1'b1;

        // R9: initialization pass
        set_pat(0);
        b = log_n; idn = n_idone;
        pulse(1'b1, 1'b0, 0, 0);
        wait_idle();
        exp_init();
        cmp_log(b, "R9 init sequence");
        check(n_idone - idn == 1, "R9 init_done pulses", n_idone - idn, 1);

        // R2 R3 R4 R5 R6 R7 R8: every reaction under each dependency layout
        for (int p = 0; p < 4; p++) begin
            set_pat(p);
            for (int mu = 0; mu < NR; mu++) begin
                int tm = 100 * (p + 1) + 3 * mu;
                b = log_n; cd = n_cdone;
                pulse(1'b0, 1'b1, mu, tm);
                wait_idle();
                exp_cycle(mu, tm);
                cmp_log(b, "R2 R3 R4 R5 R6 cycle sequence");
                check(n_cdone - cd == 1, "R8 cycle_done pulses", n_cdone - cd, 1);
                check(int'(sim_time) == tm, "R8 sim_time", int'(sim_time), tm);
                if (p == 0) check(count_unit(b, U_TMOD) == 3, "R5 d-1 modifications",
                                  count_unit(b, U_TMOD), 3);
                if (p == 2) check(count_unit(b, U_TMOD) == 0, "R6 self entries skipped",
                                  count_unit(b, U_TMOD), 0);
                if (p == 1 && mu == 0) check(log_n - b == 5, "R7 empty list ends cycle",
                                             log_n - b, 5);
            end
        end

        // R11: starts while busy are ignored
        set_pat(0);
        b = log_n; cd = n_cdone; idn = n_idone;
        pulse(1'b0, 1'b1, 1, 77);
        repeat (3) @(negedge clk);
        pulse(1'b1, 1'b1, 2, 999);
        wait_idle();
        exp_cycle(1, 77);
        cmp_log(b, "R11 busy starts ignored");
        check(n_cdone - cd == 1 && n_idone == idn, "R11 single completion",
              n_cdone - cd, 1);
        check(int'(sim_time) == 77, "R11 sim_time unchanged by late start",
              int'(sim_time), 77);

        // R11 R9: simultaneous starts choose init, which clears sim_time
        b = log_n; cd = n_cdone; idn = n_idone;
        pulse(1'b1, 1'b1, 3, 55);
        wait_idle();
        exp_init();
        cmp_log(b, "R11 init priority");
        check(n_idone - idn == 1 && n_cdone == cd, "R11 init wins", n_idone - idn, 1);
        check(sim_time == '0, "R9 sim_time cleared", int'(sim_time), 0);

        // R10: no overlapping requests during the whole run
        check(ovl == 0, "R10 one outstanding request", ovl, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule